// File: doc/BRIEF.md
# Port-Aware Carrier Loss Monitor

This block watches each frame transmission and decides whether carrier came back from the attached medium unit while the frame went out. Carrier sense arrives from outside the clock domain and is resynchronized first. While transmit-active is high, two pieces of evidence build up. The first is whether carrier has been seen. The second is whether carrier fell again after it was seen. When transmit-active falls, one decision is made and latched as the loss-of-carrier flag.

The decision depends on the selected physical port and on the loopback mode. On the attachment-unit and general-purpose serial ports, the frame is flagged when carrier never shows up or drops before the end. On the twisted-pair port, the flag follows the link-fail input seen during the frame. The on-chip digital port loops back internally and is never flagged. Internal loopback also suppresses the check. External loopback applies the normal rule of the selected port.

The flag is also presented as bit 7 of an 8-bit transmit status word. The flag only reports the condition. It never leads to a retry of the frame.

Top module: `carrier_loss_monitor`

## Requirements
- R1: After reset, `lcar_flag`, `frame_done` and `tx_status` are all zero.
- R2: `frame_done` pulses high for exactly one cycle, in the cycle after the first clock edge at which `tx_active` is sampled low following a high sample.
- R3: With port code 0 (attachment-unit) or 2 (general-purpose serial), and loopback code 0 or 2, a frame in which the synchronized carrier is never high sets the flag.
- R4: On those ports, a frame whose synchronized carrier rises and later falls while the frame is active sets the flag. A frame whose synchronized carrier is high over the whole frame clears it.
- R5: Carrier and link-fail evidence is cleared at the start of each frame, so a good earlier frame does not mask a later faulty one.
- R6: With port code 1 (twisted-pair) and loopback code not 1, the flag is set exactly when `link_fail` is high in at least one transmit-active cycle. Carrier has no effect on that port.
- R7: With port code 3 (on-chip digital), the flag is cleared at the end of every frame, whatever the carrier and link fail do.
- R8: With loopback code 1 (internal), the flag is cleared at the end of every frame on every port.
- R9: Loopback codes 2 (external) and 3 give the same result as code 0 for the selected port.
- R10: Between frame ends, `lcar_flag` holds its value regardless of the carrier, link-fail, port or loopback inputs.
- R11: Carrier is observed through a two-stage synchronizer. Carrier first driven high in the last transmit-active cycle of a frame is therefore not counted.
- R12: `tx_status` bit 7 equals `lcar_flag` and all other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | High while a frame is being transmitted |
| carrier_in | input | 1 | Asynchronous carrier sense from the medium unit |
| port_sel | input | 2 | 0 attachment-unit, 1 twisted-pair, 2 general-purpose serial, 3 on-chip digital |
| loop_mode | input | 2 | 0 none, 1 internal, 2 external, 3 treated as none |
| link_fail | input | 1 | Twisted-pair link-fail state |
| lcar_flag | output | 1 | Latched loss-of-carrier result of the last frame |
| frame_done | output | 1 | One-cycle pulse when a new result is latched |
| tx_status | output | 8 | Transmit status word carrying the flag at bit 7 |

## Verification
A wrong sticky bit in the tracker stays hidden until the frame ends. It then shows as a wrong `lcar_flag` in the same cycle as `frame_done`, one cycle after transmit-active is sampled low. A stale bit carried over from the previous frame shows up only when a faulty frame follows a good one. The bench therefore runs frames back to back. A wrong synchronizer depth moves the carrier window by a cycle, which only frames whose carrier changes near the start or end of transmission can reveal. The directed cases aim at those edges.

// File: rtl/clm_pkg.sv
package clm_pkg;

  typedef enum logic [1:0] {
    PORT_AUI  = 2'd0,
    PORT_TP   = 2'd1,
    PORT_GPSI = 2'd2,
    PORT_DAI  = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    LB_NONE     = 2'd0,
    LB_INTERNAL = 2'd1,
    LB_EXTERNAL = 2'd2,
    LB_SPARE    = 2'd3
  } lb_e;

  // End-of-frame decision: one when loss of carrier is to be reported.
  function automatic logic lcar_decide(input port_e p, input lb_e lb,
                                       input logic seen, input logic dropped,
                                       input logic lf_seen);
    logic r;
    r = 1'b0;
    if (lb != LB_INTERNAL) begin
      unique case (p)
        PORT_AUI, PORT_GPSI: r = ~seen | dropped;
        PORT_TP:             r = lf_seen;
        default:             r = 1'b0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/clm_sync.sv
module clm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clm_tracker.sv
module clm_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic crs_s,
  input  logic link_fail,
  output logic end_evt,
  output logic seen,
  output logic dropped,
  output logic lf_seen
);
  logic tx_q;
  logic start_evt;

  assign start_evt = tx_active & ~tx_q;
  assign end_evt   = tx_q & ~tx_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q    <= 1'b0;
      seen    <= 1'b0;
      dropped <= 1'b0;
      lf_seen <= 1'b0;
    end else begin
      tx_q <= tx_active;
      if (tx_active) begin
        if (start_evt) begin
          seen    <= crs_s;
          dropped <= 1'b0;
          lf_seen <= link_fail;
        end else begin
          seen    <= seen | crs_s;
          dropped <= dropped | (seen & ~crs_s);
          lf_seen <= lf_seen | link_fail;
        end
      end
    end
  end

  AST_DROP_NEEDS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |-> seen); // R4
  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !end_evt); // R2
endmodule

// File: rtl/clm_judge.sv
module clm_judge
  import clm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  end_evt,
  input  port_e port,
  input  lb_e   lb,
  input  logic  seen,
  input  logic  dropped,
  input  logic  lf_seen,
  output logic  lcar_flag,
  output logic  frame_done
);
  logic verdict;

  assign verdict = lcar_decide(port, lb, seen, dropped, lf_seen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcar_flag  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= end_evt;
      if (end_evt) lcar_flag <= verdict;
    end
  end

  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> frame_done); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(lcar_flag)); // R10
  AST_INTERNAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && $past(lb == LB_INTERNAL) |-> !lcar_flag); // R8
  AST_DAI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && $past(port == PORT_DAI) |-> !lcar_flag); // R7
  AST_TP_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && $past(port == PORT_TP && lb != LB_INTERNAL)
    |-> (lcar_flag == $past(lf_seen))); // R6
endmodule

// File: rtl/carrier_loss_monitor.sv
module carrier_loss_monitor
  import clm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_W    = 8,
  parameter int LCAR_BIT    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_active,
  input  logic                carrier_in,
  input  logic [1:0]          port_sel,
  input  logic [1:0]          loop_mode,
  input  logic                link_fail,
  output logic                lcar_flag,
  output logic                frame_done,
  output logic [STATUS_W-1:0] tx_status
);
  logic crs_s;
  logic end_evt;
  logic seen;
  logic dropped;
  logic lf_seen;

  clm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (carrier_in),
    .q     (crs_s)
  );

  clm_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .crs_s     (crs_s),
    .link_fail (link_fail),
    .end_evt   (end_evt),
    .seen      (seen),
    .dropped   (dropped),
    .lf_seen   (lf_seen)
  );

  clm_judge u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .end_evt    (end_evt),
    .port       (port_e'(port_sel)),
    .lb         (lb_e'(loop_mode)),
    .seen       (seen),
    .dropped    (dropped),
    .lf_seen    (lf_seen),
    .lcar_flag  (lcar_flag),
    .frame_done (frame_done)
  );

  always_comb begin
    tx_status           = '0;
    tx_status[LCAR_BIT] = lcar_flag;
  end

  AST_STATUS_ONLY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tx_status) <= 1); // R12
endmodule

// File: tb/tb_carrier_loss_monitor.sv
module tb_carrier_loss_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0;
  logic carrier_in = 1'b0;
  logic [1:0] port_sel = 2'd0;
  logic [1:0] loop_mode = 2'd0;
  logic link_fail = 1'b0;
  logic lcar_flag;
  logic frame_done;
  logic [7:0] tx_status;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // carrier history as seen by the bench: previous two driven values
  logic prev1 = 1'b0;
  logic prev2 = 1'b0;
  logic eff [0:127];
  logic lfa [0:127];
  int   n = 0;
  logic held = 1'b0;

  always #5 clk = ~clk;

  carrier_loss_monitor dut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .carrier_in(carrier_in),
    .port_sel(port_sel), .loop_mode(loop_mode), .link_fail(link_fail),
    .lcar_flag(lcar_flag), .frame_done(frame_done), .tx_status(tx_status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected result from the recorded frame window.
  function automatic logic expect_flag(input int p, input int lb);
    logic any_on, lost, lf_any;
    any_on = 1'b0; lost = 1'b0; lf_any = 1'b0;
    for (int i = 0; i < n; i++) begin
      lf_any = lf_any | lfa[i];
      if (eff[i]) any_on = 1'b1;
      else if (any_on) lost = 1'b1;
    end
    if (lb == 1) return 1'b0;
    if (p == 3) return 1'b0;
    if (p == 1) return lf_any;
    return !any_on || lost;
  endfunction

  // one clock: called at a falling edge, returns at the next falling edge
  task automatic tick(input logic t, input logic c, input logic l);
    tx_active = t; carrier_in = c; link_fail = l;
    if (t) begin
      eff[n] = prev2;
      lfa[n] = l;
      n++;
    end
    prev2 = prev1;
    prev1 = c;
    @(negedge clk);
  endtask

  // kind: 0 always on, 1 never on, 2 on then drop, 3 rises late, 4 random,
  //       5 on only in last cycle
  function automatic logic crs_for(input int kind, input int i, input int len, input int cut);
    case (kind)
      0: return 1'b1;
      1: return 1'b0;
      2: return (i < cut);
      3: return (i >= cut);
      4: return 1'($urandom_range(0, 1));
      default: return (i == len - 1);
    endcase
  endfunction

  task automatic frame(input int p, input int lb, input int len, input int kind,
                       input int lf_mode, input string req);
    int cut;
    logic e;
    cut = (len > 4) ? $urandom_range(3, len - 1) : 3;
    port_sel = 2'(p); loop_mode = 2'(lb);
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, (kind == 0 || kind == 2) ? 1'b1 : 1'b0, 1'($urandom_range(0, 1)));
      check(frame_done == 1'b0 && lcar_flag == held, "R10", lcar_flag, held);
    end
    n = 0;
    for (int i = 0; i < len; i++) begin
      logic l;
      l = (lf_mode == 1) ? 1'b1 : (lf_mode == 2) ? (i == len / 2) : 1'b0;
      tick(1'b1, crs_for(kind, i, len, cut), l);
      check(frame_done == 1'b0 && lcar_flag == held, "R10", lcar_flag, held);
    end
    tick(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    e = expect_flag(p, lb);
    check(frame_done == 1'b1, "R2", frame_done, 1);
    check(lcar_flag == e, req, lcar_flag, e);
    check(tx_status == {e, 7'b0}, "R12", tx_status, {e, 7'b0});
    held = e;
    port_sel = 2'($urandom_range(0, 3)); loop_mode = 2'($urandom_range(0, 3));
    tick(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    check(frame_done == 1'b0, "R2", frame_done, 0);
    check(lcar_flag == held, "R10", lcar_flag, held);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    check(lcar_flag == 1'b0, "R1", lcar_flag, 0);
    check(frame_done == 1'b0, "R1", frame_done, 0);
    check(tx_status == 8'h00, "R1", tx_status, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    frame(0, 0, 10, 0, 0, "R4");   // carrier throughout: clear
    frame(0, 0, 10, 1, 0, "R3");   // no carrier: set
    frame(2, 0, 10, 1, 0, "R3");
    frame(0, 0, 12, 2, 0, "R4");   // drop mid-frame
    frame(2, 2, 12, 2, 0, "R9");
    frame(0, 0, 10, 0, 0, "R5");
    frame(0, 0, 10, 1, 0, "R5");   // good frame must not mask this one
    frame(0, 0, 8, 5, 0, "R11");   // carrier only in last cycle: not counted
    frame(1, 0, 10, 1, 0, "R6");   // no link fail, no carrier: clear
    frame(1, 0, 10, 0, 2, "R6");   // one link-fail cycle: set
    frame(1, 0, 10, 0, 0, "R5");
    frame(3, 0, 10, 1, 1, "R7");
    frame(0, 1, 10, 1, 0, "R8");
    frame(1, 1, 10, 1, 1, "R8");
    frame(0, 2, 10, 1, 0, "R9");
    frame(2, 3, 10, 2, 0, "R9");
    frame(0, 0, 1, 1, 0, "R3");

    // constrained random frames
    for (int k = 0; k < 300; k++) begin
      int p, lb;
      string tag;
      p  = $urandom_range(0, 3);
      lb = $urandom_range(0, 3);
      if (lb == 1) tag = "R8";
      else if (p == 3) tag = "R7";
      else if (p == 1) tag = "R6";
      else tag = "R4";
      frame(p, lb, $urandom_range(1, 40), $urandom_range(0, 5), $urandom_range(0, 2), tag);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule